// File: doc/BRIEF.md
# Display standby timeout controller

This block sequences the power modes of one display driver chip in a two-chip display set. While the CPU power-on input is high the set is in RUN. Display timing then comes from the CPU clock phases, and the local low-speed timebase is held off. When the CPU drops its power-on input, the block moves to STANDBY. In STANDBY a master chip enables its local timebase and counts the ticks of that timebase. When the count reaches a fixed limit, the block drops its display-power output, and the system falls into SLEEP.

A strap input selects the chip's role. A master clocks its counter from its own gated timebase and also drives that gated tick onto a shared line. A slave ignores its own timebase and counts the pulses on the shared line, so the counters of both chips stay in step. The timebase itself is not part of the block: it arrives as an asynchronous tick input. Every tick line passes through a synchroniser and an edge detector before it reaches the counter.

The timeout limit is the parameter `TIMEOUT_TICKS`. Its default is 9 x 2^19 = 4,718,592 ticks, which is roughly eleven minutes at a nominal 7 kHz tick rate. A simulation can set a much smaller limit.

Top module: `disp_standby_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with `cpu_pwr_on` low, the block is in SLEEP. In SLEEP `disp_pwr` is 0, `osc_en` is 0 and `shared_tick_out` is 0.
- R2: `osc_en` is 1 exactly when `is_master` is 1, `disp_pwr` is 1 and `cpu_pwr_on` is 0. Otherwise it is 0.
- R3: `cpu_pwr_on` high, seen at a clock edge in any mode, puts the block into RUN at that edge. `disp_pwr` is 1 from then on, and the timeout count is cleared.
- R4: `cpu_pwr_on` low, seen at a clock edge in RUN, moves the block to STANDBY. `disp_pwr` stays 1.
- R5: In STANDBY, `disp_pwr` and `osc_en` fall after exactly `TIMEOUT_TICKS` counted tick rising edges. They fall at the third clock edge after the last counted tick line goes high. After `TIMEOUT_TICKS`-1 counted ticks, `disp_pwr` is still 1.
- R6: A master drives `shared_tick_out` equal to `local_tick` while `osc_en` is 1, and drives 0 otherwise, which includes RUN. A slave always drives 0.
- R7: A slave counts rising edges of `shared_tick_in` and ignores `local_tick`. A master counts its gated `local_tick` and ignores `shared_tick_in`.
- R8: Ticks that arrive in RUN are not counted. A STANDBY period that is cut short by RUN restarts from zero and needs a full `TIMEOUT_TICKS` ticks.
- R9: In SLEEP, ticks have no effect, and `disp_pwr` stays 0 until `cpu_pwr_on` goes high.
- R10: The counter advances once for each rising edge of the selected tick line. A tick line that is held high for many clock cycles counts as a single tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_pwr_on | input | 1 | CPU power-on level; high means RUN |
| is_master | input | 1 | Role strap: 1 for master, 0 for slave |
| local_tick | input | 1 | Asynchronous tick from this chip's timebase |
| shared_tick_in | input | 1 | Asynchronous tick from the shared line, driven by the master |
| osc_en | output | 1 | Enable for the local timebase |
| shared_tick_out | output | 1 | Tick driven onto the shared line |
| disp_pwr | output | 1 | Display-power output; low in SLEEP |

## Verification
Mode changes driven by `cpu_pwr_on` appear one clock edge after the input changes. `osc_en` and `shared_tick_out` follow their inputs within the same cycle. A tick is counted at the third clock edge after its line rises, because of the two synchroniser flops and the edge register. The bench therefore holds each tick high for four cycles and low for four more, and it reads `disp_pwr` only after a whole pulse is over. All stimulus is driven on falling clock edges, and all outputs are read on falling clock edges. Both straps are swept with a small limit of 36 ticks, and each sweep checks the output after every single tick, up to and just past the limit.

// File: rtl/disp_standby_pkg.sv
package disp_standby_pkg;

   typedef enum logic [1:0] {
      PM_SLEEP   = 2'd0,
      PM_RUN     = 2'd1,
      PM_STANDBY = 2'd2
   } pm_mode_e;

   localparam int unsigned DEFAULT_TIMEOUT = 9 * (2 ** 19);

endpackage

// File: rtl/dsc_tick_sync.sv
module dsc_tick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

   // R10: a held-high line yields one detection pulse only
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/dsc_timeout_cnt.sv
module dsc_timeout_cnt #(
   parameter int unsigned LIMIT = 36
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic done
);
   localparam int unsigned W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);
   localparam logic [W-1:0] TOP  = W'(LIMIT);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clear)                  cnt_q <= '0;
      else if (step && cnt_q != TOP)   cnt_q <= cnt_q + 1'b1;
   end

   assign done = step && (cnt_q == LAST);

   // R8: a clear leaves the count at zero on the next cycle
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));
   // R10: the count moves by at most one per cycle
   a_r10_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
   // R5: the count never passes the limit
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP);

endmodule

// File: rtl/dsc_mode_fsm.sv
module dsc_mode_fsm
   import disp_standby_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cpu_pwr_on,
   input  logic     done,
   output pm_mode_e mode,
   output logic     disp_pwr
);
   pm_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         PM_SLEEP:   if (cpu_pwr_on) mode_d = PM_RUN;
         PM_RUN:     if (!cpu_pwr_on) mode_d = PM_STANDBY;
         PM_STANDBY: begin
            if (cpu_pwr_on) mode_d = PM_RUN;
            else if (done)  mode_d = PM_SLEEP;
         end
         default:    mode_d = PM_SLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PM_SLEEP;
      else        mode_q <= mode_d;
   end

   assign mode     = mode_q;
   assign disp_pwr = (mode_q != PM_SLEEP);

   // R5: a finished count in STANDBY ends in SLEEP
   a_r5_timeout_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_STANDBY && done && !cpu_pwr_on) |=> (mode_q == PM_SLEEP));
   // R3: CPU power-on always restores display power
   a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_pwr_on |=> disp_pwr);
   // R9: SLEEP persists without CPU power-on
   a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_pwr && !cpu_pwr_on) |=> !disp_pwr);
   // R4: RUN left with power-on low goes to STANDBY
   a_r4_to_standby: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN && !cpu_pwr_on) |=> (mode_q == PM_STANDBY));

endmodule

// File: rtl/disp_standby_ctrl.sv
module disp_standby_ctrl
   import disp_standby_pkg::*;
#(
   parameter int unsigned TIMEOUT_TICKS = DEFAULT_TIMEOUT,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_pwr_on,
   input  logic is_master,
   input  logic local_tick,
   input  logic shared_tick_in,
   output logic osc_en,
   output logic shared_tick_out,
   output logic disp_pwr
);
   generate
      if (TIMEOUT_TICKS < 2) begin : g_bad_limit
         $error("TIMEOUT_TICKS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   pm_mode_e mode;
   logic     tick_gated;
   logic     count_src;
   logic     tick_rise;
   logic     step;
   logic     clear;
   logic     done;

   assign osc_en          = is_master & disp_pwr & ~cpu_pwr_on;
   assign tick_gated      = osc_en & local_tick;
   assign shared_tick_out = tick_gated;
   assign count_src       = is_master ? tick_gated : shared_tick_in;

   dsc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (count_src),
      .rise     (tick_rise)
   );

   assign step  = tick_rise && (mode == PM_STANDBY) && !cpu_pwr_on;
   assign clear = (mode == PM_RUN);

   dsc_timeout_cnt #(.LIMIT(TIMEOUT_TICKS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .step  (step),
      .done  (done)
   );

   dsc_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_pwr_on (cpu_pwr_on),
      .done       (done),
      .mode       (mode),
      .disp_pwr   (disp_pwr)
   );

   // R6: a slave never drives the shared line
   a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !is_master |-> !shared_tick_out);
   // R2: the timebase is off in SLEEP
   a_r2_sleep_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_pwr |-> !osc_en);
   // R8: no count steps in RUN
   a_r8_run_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_RUN) |-> !step);

endmodule

// File: tb/tb_disp_standby_ctrl.sv
module tb_disp_standby_ctrl;
   localparam int unsigned LIM = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_pwr_on = 1'b0;
   logic is_master = 1'b1;
   logic local_tick = 1'b0;
   logic shared_tick_in = 1'b0;
   logic osc_en, shared_tick_out, disp_pwr;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   disp_standby_ctrl #(.TIMEOUT_TICKS(LIM), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_pwr_on(cpu_pwr_on), .is_master(is_master),
      .local_tick(local_tick), .shared_tick_in(shared_tick_in),
      .osc_en(osc_en), .shared_tick_out(shared_tick_out), .disp_pwr(disp_pwr)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one tick on the chosen line: high 4 cycles (or hold), low 4 cycles
   task automatic pulse(input bit on_shared, input int hold);
      if (on_shared) shared_tick_in = 1'b1; else local_tick = 1'b1;
      cyc(hold);
      if (on_shared) shared_tick_in = 1'b0; else local_tick = 1'b0;
      cyc(4);
   endtask

   task automatic count_line(input bit m, output bit sh);
      sh = (m == 1'b0);
   endtask

   task automatic run_strap(input bit m);
      bit sh;
      count_line(m, sh);
      is_master = m;
      cyc(2);
      // wake from SLEEP
      cpu_pwr_on = 1'b1;
      cyc(1);
      chk(disp_pwr, 1'b1, "R3 wake from sleep");
      chk(osc_en, 1'b0, "R2 osc off in run");
      // ticks in RUN on both lines
      local_tick = 1'b1;
      cyc(2);
      chk(shared_tick_out, 1'b0, "R6 shared low in run");
      local_tick = 1'b0;
      cyc(3);
      for (int i = 0; i < 5; i++) begin
         pulse(1'b0, 4);
         pulse(1'b1, 4);
      end
      // enter STANDBY
      cpu_pwr_on = 1'b0;
      cyc(1);
      chk(disp_pwr, 1'b1, "R4 standby keeps power");
      chk(osc_en, m, "R2 osc enable in standby");
      // first tick held long: counts once
      if (!sh) begin
         local_tick = 1'b1;
         cyc(2);
         chk(shared_tick_out, 1'b1, "R6 master drives shared");
         cyc(18);
         local_tick = 1'b0;
         cyc(4);
      end else begin
         local_tick = 1'b1;
         cyc(2);
         chk(shared_tick_out, 1'b0, "R6 slave shared low");
         local_tick = 1'b0;
         cyc(2);
         pulse(1'b1, 20);
      end
      chk(disp_pwr, 1'b1, "R10 held tick counted once");
      for (int k = 2; k < LIM; k++) begin
         pulse(sh, 4);
         if (sh) pulse(1'b0, 4);   // slave: own timebase ignored
         else    pulse(1'b1, 4);   // master: shared input ignored
         chk(disp_pwr, 1'b1, "R7 before limit");
      end
      pulse(sh, 4);
      chk(disp_pwr, 1'b0, "R5 timeout reached");
      chk(osc_en, 1'b0, "R5 osc off at timeout");
      chk(shared_tick_out, 1'b0, "R1 sleep shared low");
      // ticks in SLEEP
      for (int i = 0; i < 4; i++) begin
         pulse(1'b0, 4);
         pulse(1'b1, 4);
      end
      chk(disp_pwr, 1'b0, "R9 sleep holds");
      // interrupted standby must restart
      cpu_pwr_on = 1'b1;
      cyc(1);
      chk(disp_pwr, 1'b1, "R3 wake again");
      cpu_pwr_on = 1'b0;
      cyc(1);
      for (int k = 1; k < LIM; k++) pulse(sh, 4);
      chk(disp_pwr, 1'b1, "R8 near limit");
      cpu_pwr_on = 1'b1;
      cyc(2);
      cpu_pwr_on = 1'b0;
      cyc(1);
      for (int k = 1; k < LIM; k++) pulse(sh, 4);
      chk(disp_pwr, 1'b1, "R8 count restarted");
      pulse(sh, 4);
      chk(disp_pwr, 1'b0, "R5 full count after restart");
   endtask

   initial begin
      cyc(1);
      chk(disp_pwr, 1'b0, "R1 reset power");
      chk(osc_en, 1'b0, "R1 reset osc");
      chk(shared_tick_out, 1'b0, "R1 reset shared");
      cyc(2);
      rst_n = 1'b1;
      cyc(3);
      chk(disp_pwr, 1'b0, "R1 sleep after reset");
      run_strap(1'b1);
      run_strap(1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule